// File: doc/BRIEF.md
# Pipelined Finite-Field Exponentiator

This block raises an element A of the binary extension field GF(2^M) to an M-bit power E. It accepts one (A, E) pair on every clock cycle and returns A^E a fixed number of cycles later. The input pairs stream through the block at full rate.

The computation is left-to-right square-and-multiply. A running value is seeded with A if the top exponent bit is set, and with 1 otherwise. It then passes through M-1 cascaded power-sum stages. Each stage forms op·r², where op is A or 1 according to the next lower exponent bit. The addend input of each power-sum stage is held at zero.

Each stage is a bit-serial multiplier unrolled into M register levels. Every level consumes one bit of r², most significant bit first, and does a single shift, reduce and accumulate step. A, E and the valid flag ride alongside the running value through every level, so each result stays tied to its own operands.

The field polynomial is a parameter. It is given as its low M coefficients.

Top module: `gf_exp_pipe`

## Requirements
- R1: For every A and E in GF(2^M), `out_res` equals A^E reduced by the polynomial x^M + POLY, where bit i of a value is the coefficient of x^i.
- R2: A pair presented with `in_valid` high before a clock edge appears on `out_res` with `out_valid` high exactly M·(M-1) cycles later.
- R3: A new pair may be presented on every cycle, and back-to-back pairs come out on consecutive cycles in the order they went in.
- R4: `out_valid` is high only in cycles whose matching input cycle had `in_valid` high; bubbles in the input show up as bubbles at the output.
- R5: E = 0 yields 1 for every A, including A = 0.
- R6: A = 0 with E ≠ 0 yields 0.
- R7: E = 1 yields A.
- R8: While `rst` is high, and until the first valid pair has crossed the whole pipeline after reset, `out_valid` stays low; a reset discards all pairs in flight.
- R9: A = 1 yields 1 for every E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all valid flags |
| in_valid | input | 1 | Marks `in_a`/`in_e` as a pair to process this cycle |
| in_a | input | M | Base field element |
| in_e | input | M | Exponent, unsigned |
| out_valid | output | 1 | `out_res` holds a result |
| out_res | output | M | A^E for the pair entered M·(M-1) cycles earlier |

## Verification
Some properties are checked by assertions on every cycle at the last pipeline level. These are the algebraic identities for E = 0, E = 1, A = 0 and A = 1, plus the rule that no result appears sooner than a full pipeline length after reset. Only the bench can show the following: the general value of A^E over the whole operand space, the exact latency, the ordering under back-to-back issue, bubble preservation, and the loss of in-flight pairs on reset. It does this by sweeping every (A, E) pair of a 4-bit field, both streamed and gapped, and comparing each result against a power computed by repeated multiplication.

// File: rtl/gf_exp_pipe.sv
module gf_exp_pipe #(
  parameter int M    = 8,
  parameter int POLY = 'h1B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_e,
  output logic         out_valid,
  output logic [M-1:0] out_res
);
  localparam int L  = M * (M - 1);
  localparam int FW = $clog2(L + 1);
  localparam logic [M-1:0] PL  = POLY[M-1:0];
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  typedef struct packed {
    logic         v;
    logic [M-1:0] a;
    logic [M-1:0] e;
    logic [M-1:0] r;
    logic [M-1:0] acc;
  } lvl_t;

  lvl_t src [0:L-1];
  lvl_t d   [1:L];
  lvl_t q   [1:L];

  function automatic logic [M-1:0] xt(input logic [M-1:0] x);
    return {x[M-2:0], 1'b0} ^ (x[M-1] ? PL : '0);
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] p;
    p = '0;
    for (int b = M - 1; b >= 0; b--) p = xt(p) ^ (y[b] ? x : '0);
    return p;
  endfunction

  always_comb begin
    src[0].v   = in_valid;
    src[0].a   = in_a;
    src[0].e   = in_e;
    src[0].r   = in_e[M-1] ? in_a : ONE;
    src[0].acc = '0;
    for (int i = 1; i < L; i++) src[i] = q[i];
    for (int i = 0; i < L; i++) begin
      int k;
      int j;
      logic [M-1:0] op;
      logic [M-1:0] sq;
      logic [M-1:0] base;
      logic [M-1:0] nacc;
      k    = i / M + 1;
      j    = i % M;
      op   = src[i].e[M-1-k] ? src[i].a : ONE;
      sq   = gmul(src[i].r, src[i].r);
      base = (j == 0) ? '0 : src[i].acc;
      nacc = xt(base) ^ (sq[M-1-j] ? op : '0);
      d[i+1]     = src[i];
      d[i+1].acc = nacc;
      if (j == M - 1) d[i+1].r = nacc;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 1; i <= L; i++) begin
      q[i]   <= d[i];
      q[i].v <= rst ? 1'b0 : d[i].v;
    end
  end

  assign out_valid = q[L].v;
  assign out_res   = q[L].r;

  logic [FW-1:0] fill;
  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else if (fill != FW'(L)) fill <= fill + 1'b1;
  end

  assert_no_early_result_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> fill == FW'(L));

  assert_zero_exp_one_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q[L].e == '0) |-> out_res == ONE);

  assert_zero_base_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q[L].a == '0 && q[L].e != '0) |-> out_res == '0);

  assert_unit_exp_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q[L].e == ONE) |-> out_res == q[L].a);

  assert_unit_base_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q[L].a == ONE) |-> out_res == ONE);
endmodule

// File: tb/gf_exp_pipe_bench.sv
`timescale 1ns/1ps
module gf_exp_pipe_bench;
  localparam int M    = 4;
  localparam int POLY = 'h3;
  localparam int L    = M * (M - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [M-1:0] in_a = '0;
  logic [M-1:0] in_e = '0;
  logic out_valid;
  logic [M-1:0] out_res;

  gf_exp_pipe #(.M(M), .POLY(POLY)) u_gf_exp_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_e(in_e),
    .out_valid(out_valid), .out_res(out_res)
  );

  always #2.5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic         rv [0:L];
  logic [M-1:0] ra [0:L];
  logic [M-1:0] re [0:L];

  function automatic int fmul(int x, int y);
    int p = 0;
    int xx = x;
    for (int b = 0; b < M; b++) begin
      if ((y >> b) & 1) p ^= xx;
      xx = xx << 1;
      if (xx & (1 << M)) xx ^= (1 << M) | POLY;
    end
    return p;
  endfunction

  function automatic int fpow(int x, int e);
    int r = 1;
    for (int n = 0; n < e; n++) r = fmul(r, x);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic clear_ring();
    for (int i = 0; i <= L; i++) rv[i] = 1'b0;
  endtask

  task automatic step(bit v, int a, int e);
    int ri;
    int wi;
    int ex;
    @(negedge clk);
    rst = 1'b0;
    ri = (cyc + 1) % (L + 1);
    wi = cyc % (L + 1);
    if (rv[ri]) begin
      ex = fpow(ra[ri], re[ri]);
      check(out_valid == 1'b1, "R2 R3 R4 valid", out_valid, 1);
      if (re[ri] == 0)      check(out_res == M'(ex), "R5", out_res, ex);
      else if (ra[ri] == 0) check(out_res == M'(ex), "R6", out_res, ex);
      else if (re[ri] == 1) check(out_res == M'(ex), "R7", out_res, ex);
      else if (ra[ri] == 1) check(out_res == M'(ex), "R9", out_res, ex);
      else                  check(out_res == M'(ex), "R1", out_res, ex);
    end else begin
      check(out_valid == 1'b0, "R4 R8 bubble", out_valid, 0);
    end
    in_valid = v;
    in_a = M'(a);
    in_e = M'(e);
    rv[wi] = v;
    ra[wi] = M'(a);
    re[wi] = M'(e);
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    clear_ring();
    cyc++;
  endtask

  initial begin
    clear_ring();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset state", out_valid, 0);
    // R3: every pair back to back
    for (int p = 0; p < (1 << (2 * M)); p++) step(1'b1, p >> M, p & ((1 << M) - 1));
    for (int n = 0; n <= L; n++) step(1'b0, 0, 0);
    // R4: gapped stream with varying pattern
    for (int p = 0; p < (1 << (2 * M)); p++)
      step((p % 3) != 1, (p * 7) & ((1 << M) - 1), (p * 5 + 3) & ((1 << M) - 1));
    for (int n = 0; n <= L; n++) step(1'b0, 0, 0);
    // R2: single pair, sharp edge of latency window
    step(1'b1, 3, 6);
    for (int n = 0; n <= L + 1; n++) step(1'b0, 0, 0);
    // R8: reset discards in-flight pairs
    for (int n = 0; n < 8; n++) step(1'b1, n + 2, n + 5);
    do_reset();
    for (int n = 0; n < L + 3; n++) step(1'b0, 0, 0);
    step(1'b1, 2, 3);
    for (int n = 0; n <= L + 1; n++) step(1'b0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule